// File: doc/BRIEF.md
# Multi-Stream Sequential Data Prefetcher

This block observes every memory access the core makes and learns sequential runs of 32-byte cache lines, running upward or downward in the address space. Loads, stores and instruction fetches all train the same table of eight streams. Once a stream has been extended three times, the access that extends it starts a prefetch of the two lines that lie beyond it in the stream's direction. A step of one or two lines extends a stream, so a run with an occasional missing line still counts. A run with wider strides never qualifies.

Each prefetched line is first looked up in the second-level cache. Only a line that misses there is passed on to the bus request queue. A small issue engine walks the lines one at a time through four named states:
- IDLE: waiting for a trigger.
- LOOKUP: drives the one-cycle L2 request.
- WAIT: holds until the L2 answers.
- BUS: drives the one-cycle bus request.

The transitions are:
- start (IDLE to LOOKUP): a trigger arrives and at least one target line lies in the page.
- sent (LOOKUP to WAIT).
- hit-next (WAIT to LOOKUP): a hit with lines left.
- hit-done (WAIT to IDLE): a hit on the last line.
- miss (WAIT to BUS).
- bus-next (BUS to LOOKUP).
- bus-done (BUS to IDLE).

The engine never issues a line outside the 4 KB page of the access that triggered it.

Top module: `stream_prefetcher`

## Requirements
- R1: Accesses of kind 0 (load), 1 (store) and 2 (instruction fetch) all train streams. Kind 3 is reserved, and such an access leaves the stream table and the outputs untouched.
- R2: Streams work on line numbers, which are address bits [31:5], so the offset bits are ignored. An access 1 or 2 lines beyond a stream's last line, in the stream's direction, extends that stream. A stream with no direction yet accepts either direction. Any larger step does not extend the stream; the access opens a new stream instead.
- R3: A stream is confirmed once it has been extended three times. The extending access that confirms it, and every later extending access, requests the next 2 lines past that access in the stream's direction, nearest line first.
- R4: Descending streams behave the same way: the lines requested are the access line minus 1, then minus 2.
- R5: The line run 1,2,4,5 triggers a prefetch of lines 6 and 7. The run 1,4,7,10,13 triggers nothing.
- R6: Every prefetch line is first requested from the L2 as a one-cycle pulse. A bus request for the same line follows in the cycle after a miss response. A hit produces no bus request.
- R7: No request ever addresses a line outside the 4 KB page (128 lines) of the triggering access. When no target line lies in that page, nothing is issued.
- R8: Eight streams are held at once. An access that matches no stream replaces the least recently used entry.
- R9: A trigger that arrives while the issue engine is not idle is dropped. The stream table still advances on that access, so the next extension triggers again.
- R10: After reset all request outputs are low. The L2 and bus request pulses never overlap, and each lasts one cycle.
- R11: An access to a stream's last line again refreshes its recency without extending it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Byte address of the access |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| l2_req_valid | output | 1 | L2 lookup request pulse |
| l2_req_addr | output | 32 | Line-aligned address being looked up |
| l2_resp_valid | input | 1 | L2 answer for the pending lookup |
| l2_resp_hit | input | 1 | The looked-up line is present in L2 |
| bus_req_valid | output | 1 | Bus queue request pulse |
| bus_req_addr | output | 32 | Line-aligned address sent to the bus queue |

## Verification
The assertions take for granted that the L2 answers only while a lookup is outstanding, with exactly one response pulse per lookup request. The bus-after-miss property relies on that. The stimulus meets this through a responder that answers one cycle after each lookup pulse and is otherwise silent. The responder decides hit or miss from the line number alone, modulo 3, so both the hit and the miss paths occur in every sweep. Each stream under test sits in its own page far from the others, so no access can extend an unrelated entry.

// File: rtl/pf_pkg.sv
package pf_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LOOKUP = 2'd1,
        S_WAIT   = 2'd2,
        S_BUS    = 2'd3
    } pf_state_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } pf_dir_e;

    localparam logic [1:0] KIND_RESERVED = 2'd3;

endpackage

// File: rtl/pf_stream_table.sv
module pf_stream_table
    import pf_pkg::*;
#(
    parameter int N_STREAMS = 8,
    parameter int LINE_W    = 27,
    parameter int CONFIRM   = 3,
    parameter int MAX_STEP  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_fire,
    input  logic [LINE_W-1:0] acc_line,
    output logic              trig_valid,
    output logic [LINE_W-1:0] trig_line,
    output pf_dir_e           trig_dir
);
    localparam int AGE_W = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1;
    localparam int CNT_W = $clog2(CONFIRM + 1);

    logic [N_STREAMS-1:0] ent_valid;
    logic [N_STREAMS-1:0] ent_known;
    pf_dir_e              ent_dir  [N_STREAMS];
    logic [LINE_W-1:0]    ent_last [N_STREAMS];
    logic [CNT_W-1:0]     ent_cnt  [N_STREAMS];
    logic [AGE_W-1:0]     ent_age  [N_STREAMS];

    logic [N_STREAMS-1:0] step_up, step_dn, ext, same;

    // per-entry distance comparators
    for (genvar g = 0; g < N_STREAMS; g++) begin : g_match
        logic [LINE_W-1:0] d_fwd, d_bwd;
        assign d_fwd      = acc_line - ent_last[g];
        assign d_bwd      = ent_last[g] - acc_line;
        assign step_up[g] = (d_fwd != '0) && (d_fwd <= LINE_W'(MAX_STEP));
        assign step_dn[g] = (d_bwd != '0) && (d_bwd <= LINE_W'(MAX_STEP));
        assign same[g]    = ent_valid[g] && (d_fwd == '0);
        assign ext[g]     = ent_valid[g] &&
                            (ent_known[g] ? ((ent_dir[g] == DIR_DOWN) ? step_dn[g] : step_up[g])
                                          : (step_up[g] | step_dn[g]));
    end

    logic             hit_found;
    logic [AGE_W-1:0] hit_idx, victim, sel;
    logic             sel_ext;
    pf_dir_e          new_dir;

    always_comb begin
        hit_found = 1'b0;
        hit_idx   = '0;
        victim    = '0;
        for (int i = N_STREAMS - 1; i >= 0; i--) begin
            if (ext[i] || same[i]) begin
                hit_found = 1'b1;
                hit_idx   = AGE_W'(i);
            end
        end
        for (int i = 0; i < N_STREAMS; i++) begin
            if (ent_age[i] == AGE_W'(N_STREAMS - 1)) victim = AGE_W'(i);
        end
        sel     = hit_found ? hit_idx : victim;
        sel_ext = hit_found && ext[sel];
        if (ent_known[sel]) new_dir = ent_dir[sel];
        else                new_dir = step_dn[sel] ? DIR_DOWN : DIR_UP;
    end

    assign trig_valid = acc_fire && sel_ext && (ent_cnt[sel] >= CNT_W'(CONFIRM - 1));
    assign trig_line  = acc_line;
    assign trig_dir   = new_dir;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_known <= '0;
            for (int i = 0; i < N_STREAMS; i++) begin
                ent_dir[i]  <= DIR_UP;
                ent_last[i] <= '0;
                ent_cnt[i]  <= '0;
                ent_age[i]  <= AGE_W'(i);
            end
        end else if (acc_fire) begin
            for (int i = 0; i < N_STREAMS; i++) begin
                if (ent_age[i] < ent_age[sel]) ent_age[i] <= ent_age[i] + 1'b1;
            end
            ent_age[sel] <= '0;
            if (!hit_found) begin
                ent_valid[sel] <= 1'b1;
                ent_known[sel] <= 1'b0;
                ent_dir[sel]   <= DIR_UP;
                ent_last[sel]  <= acc_line;
                ent_cnt[sel]   <= '0;
            end else if (sel_ext) begin
                ent_known[sel] <= 1'b1;
                ent_dir[sel]   <= new_dir;
                ent_last[sel]  <= acc_line;
                if (ent_cnt[sel] < CNT_W'(CONFIRM)) ent_cnt[sel] <= ent_cnt[sel] + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pf_issue_fsm.sv
module pf_issue_fsm
    import pf_pkg::*;
#(
    parameter int LINE_W     = 27,
    parameter int OFF_W      = 5,
    parameter int PAGE_LINES = 128,
    parameter int AHEAD      = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    trig_valid,
    input  logic [LINE_W-1:0]       trig_line,
    input  pf_dir_e                 trig_dir,
    input  logic                    l2_resp_valid,
    input  logic                    l2_resp_hit,
    output logic                    l2_req_valid,
    output logic [LINE_W+OFF_W-1:0] l2_req_addr,
    output logic                    bus_req_valid,
    output logic [LINE_W+OFF_W-1:0] bus_req_addr
);
    localparam int PG_W  = $clog2(PAGE_LINES);
    localparam int REM_W = $clog2(AHEAD + 1);

    pf_state_e         state, next_state;
    logic [LINE_W-1:0] cur_line, step_line;
    logic [REM_W-1:0]  rem, start_n;
    pf_dir_e           dir_q;
    logic [PG_W-1:0]   pg_off, room;
    logic              accept, advance;

    assign pg_off    = trig_line[PG_W-1:0];
    assign room      = (trig_dir == DIR_DOWN) ? pg_off : (PG_W'(PAGE_LINES - 1) - pg_off);
    assign start_n   = (room < PG_W'(AHEAD)) ? REM_W'(room) : REM_W'(AHEAD);
    assign accept    = (state == S_IDLE) && trig_valid && (start_n != '0);
    assign step_line = (dir_q == DIR_DOWN) ? (cur_line - 1'b1) : (cur_line + 1'b1);
    assign advance   = ((state == S_WAIT) && l2_resp_valid && l2_resp_hit) || (state == S_BUS);

    // next-state logic
    always_comb begin
        next_state = state;
        unique case (state)
            S_IDLE:   if (accept) next_state = S_LOOKUP;
            S_LOOKUP: next_state = S_WAIT;
            S_WAIT:   if (l2_resp_valid) begin
                          if (!l2_resp_hit)         next_state = S_BUS;
                          else if (rem > REM_W'(1)) next_state = S_LOOKUP;
                          else                      next_state = S_IDLE;
                      end
            S_BUS:    next_state = (rem > REM_W'(1)) ? S_LOOKUP : S_IDLE;
            default:  next_state = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= next_state;
    end

    // line cursor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_line <= '0;
            rem      <= '0;
            dir_q    <= DIR_UP;
        end else if (accept) begin
            cur_line <= (trig_dir == DIR_DOWN) ? (trig_line - 1'b1) : (trig_line + 1'b1);
            rem      <= start_n;
            dir_q    <= trig_dir;
        end else if (advance) begin
            cur_line <= step_line;
            rem      <= rem - 1'b1;
        end
    end

    // outputs
    always_comb begin
        l2_req_valid  = 1'b0;
        l2_req_addr   = '0;
        bus_req_valid = 1'b0;
        bus_req_addr  = '0;
        unique case (state)
            S_LOOKUP: begin
                l2_req_valid = 1'b1;
                l2_req_addr  = {cur_line, {OFF_W{1'b0}}};
            end
            S_BUS: begin
                bus_req_valid = 1'b1;
                bus_req_addr  = {cur_line, {OFF_W{1'b0}}};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher
    import pf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int PAGE_BYTES = 4096,
    parameter int N_STREAMS  = 8,
    parameter int CONFIRM    = 3,
    parameter int MAX_STEP   = 2,
    parameter int AHEAD      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    output logic              l2_req_valid,
    output logic [ADDR_W-1:0] l2_req_addr,
    input  logic              l2_resp_valid,
    input  logic              l2_resp_hit,
    output logic              bus_req_valid,
    output logic [ADDR_W-1:0] bus_req_addr
);
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int LINE_W     = ADDR_W - OFF_W;
    localparam int PAGE_LINES = PAGE_BYTES / LINE_BYTES;

    logic              acc_fire;
    logic [LINE_W-1:0] acc_line;
    logic              unused_offset;
    logic              trig_valid;
    logic [LINE_W-1:0] trig_line;
    pf_dir_e           trig_dir;

    assign acc_fire      = acc_valid && (acc_kind != KIND_RESERVED);
    assign acc_line      = acc_addr[ADDR_W-1:OFF_W];
    assign unused_offset = ^acc_addr[OFF_W-1:0];

    pf_stream_table #(
        .N_STREAMS(N_STREAMS), .LINE_W(LINE_W), .CONFIRM(CONFIRM), .MAX_STEP(MAX_STEP)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .acc_fire(acc_fire), .acc_line(acc_line),
        .trig_valid(trig_valid), .trig_line(trig_line), .trig_dir(trig_dir)
    );

    pf_issue_fsm #(
        .LINE_W(LINE_W), .OFF_W(OFF_W), .PAGE_LINES(PAGE_LINES), .AHEAD(AHEAD)
    ) u_issue (
        .clk(clk), .rst_n(rst_n),
        .trig_valid(trig_valid), .trig_line(trig_line), .trig_dir(trig_dir),
        .l2_resp_valid(l2_resp_valid), .l2_resp_hit(l2_resp_hit),
        .l2_req_valid(l2_req_valid), .l2_req_addr(l2_req_addr),
        .bus_req_valid(bus_req_valid), .bus_req_addr(bus_req_addr)
    );

endmodule

// File: rtl/pf_checker.sv
module pf_checker (
    input logic clk,
    input logic rst_n,
    input logic l2_req_valid,
    input logic bus_req_valid,
    input logic l2_resp_valid,
    input logic l2_resp_hit
);
    p_one_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(l2_req_valid && bus_req_valid));

    p_l2_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        l2_req_valid |=> !l2_req_valid);

    p_bus_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |=> !bus_req_valid);

    p_bus_after_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req_valid) |-> $past(l2_resp_valid && !l2_resp_hit));

    p_no_bus_on_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_resp_valid && l2_resp_hit) |=> !bus_req_valid);

endmodule

bind stream_prefetcher pf_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .l2_req_valid(l2_req_valid), .bus_req_valid(bus_req_valid),
    .l2_resp_valid(l2_resp_valid), .l2_resp_hit(l2_resp_hit)
);

// File: tb/stream_prefetcher_tb.sv
module stream_prefetcher_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = 2'd0;
    logic        l2_req_valid, bus_req_valid;
    logic [31:0] l2_req_addr, bus_req_addr;
    logic        l2_resp_valid = 1'b0;
    logic        l2_resp_hit = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int got_l2 [16];
    int got_bus [16];
    int n_l2 = 0;
    int n_bus = 0;
    bit pending = 1'b0;
    int pend_line = 0;

    always #5 clk = ~clk;

    stream_prefetcher u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_kind(acc_kind), .l2_req_valid(l2_req_valid), .l2_req_addr(l2_req_addr),
        .l2_resp_valid(l2_resp_valid), .l2_resp_hit(l2_resp_hit),
        .bus_req_valid(bus_req_valid), .bus_req_addr(bus_req_addr)
    );

    function automatic bit l2_has(int line);
        return (line % 3) == 0;
    endfunction

    function automatic int pb(int p);
        return p * 128;
    endfunction

    // L2 responder and request recorder
    always @(negedge clk) begin
        if (pending) begin
            l2_resp_valid = 1'b1;
            l2_resp_hit   = l2_has(pend_line);
            pending       = 1'b0;
        end else begin
            l2_resp_valid = 1'b0;
            l2_resp_hit   = 1'b0;
        end
        if (l2_req_valid) begin
            if (n_l2 < 16) got_l2[n_l2] = int'(l2_req_addr);
            n_l2++;
            pending   = 1'b1;
            pend_line = int'(l2_req_addr) / 32;
        end
        if (bus_req_valid) begin
            if (n_bus < 16) got_bus[n_bus] = int'(bus_req_addr);
            n_bus++;
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 150000);
            finish_run();
        end
    end

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic acc(int line, logic [1:0] kind, int off = 7);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_addr  = 32'(line * 32 + off);
        acc_kind  = kind;
    endtask

    task automatic drain();
        @(negedge clk);
        acc_valid = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic clear();
        n_l2  = 0;
        n_bus = 0;
    endtask

    // expect n prefetch lines starting at first, stepping by dir
    task automatic expect_pf(string tag, int n, int first, int dir);
        int exp_bus;
        exp_bus = 0;
        check(n_l2 == n, tag, "l2 request count", n_l2, n);
        for (int k = 0; k < n; k++) begin
            int line;
            line = first + dir * k;
            if (k < n_l2 && k < 16)
                check(got_l2[k] == line * 32, tag, "l2 address", got_l2[k], line * 32);
            if (!l2_has(line)) begin
                if (exp_bus < n_bus && exp_bus < 16)
                    check(got_bus[exp_bus] == line * 32, tag, "bus address", got_bus[exp_bus], line * 32);
                exp_bus++;
            end
        end
        check(n_bus == exp_bus, tag, "bus request count", n_bus, exp_bus);
        clear();
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check(!l2_req_valid && !bus_req_valid, "R10", "outputs in reset",
              int'(l2_req_valid) + int'(bus_req_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!l2_req_valid && !bus_req_valid, "R10", "outputs after reset",
              int'(l2_req_valid) + int'(bus_req_valid), 0);
        clear();

        // R5: one skipped line still confirms
        acc(pb(1) + 11, 2'd0); acc(pb(1) + 12, 2'd0); acc(pb(1) + 14, 2'd0); acc(pb(1) + 15, 2'd0);
        drain();
        expect_pf("R5_gap", 2, pb(1) + 16, 1);

        // R5, R2: a stride of three lines never confirms
        for (int k = 0; k < 5; k++) acc(pb(3) + 1 + 3 * k, 2'd1);
        drain();
        expect_pf("R5_stride", 0, 0, 1);

        // R11: repeating the last line does not extend the stream
        acc(pb(5), 2'd0); acc(pb(5) + 1, 2'd0); acc(pb(5) + 1, 2'd0); acc(pb(5) + 2, 2'd0);
        drain();
        expect_pf("R11_repeat", 0, 0, 1);
        acc(pb(5) + 3, 2'd0);
        drain();
        expect_pf("R11_confirm", 2, pb(5) + 4, 1);

        // R1: all three kinds train, the reserved kind is ignored
        acc(pb(7), 2'd0); acc(pb(7) + 1, 2'd1); acc(pb(7) + 2, 2'd3);
        drain();
        expect_pf("R1_reserved", 0, 0, 1);
        acc(pb(7) + 3, 2'd2);
        drain();
        expect_pf("R1_not_counted", 0, 0, 1);
        acc(pb(7) + 4, 2'd1);
        drain();
        expect_pf("R1_kinds", 2, pb(7) + 5, 1);

        // R8: eight streams held at once
        for (int s = 0; s < 8; s++) begin
            acc(pb(40 + 2 * s), 2'd0); acc(pb(40 + 2 * s) + 1, 2'd0); acc(pb(40 + 2 * s) + 2, 2'd0);
        end
        drain();
        expect_pf("R8_train", 0, 0, 1);
        for (int s = 0; s < 8; s++) begin
            acc(pb(40 + 2 * s) + 3, 2'd1);
            drain();
            expect_pf("R8_eight", 2, pb(40 + 2 * s) + 4, 1);
        end
        // R8, R11: refresh stream 0, then a new stream evicts stream 1
        acc(pb(40) + 3, 2'd2);
        acc(pb(90) + 50, 2'd2);
        drain();
        expect_pf("R8_alloc", 0, 0, 1);
        acc(pb(40) + 4, 2'd0);
        drain();
        expect_pf("R8_kept", 2, pb(40) + 5, 1);
        acc(pb(42) + 4, 2'd0);
        drain();
        expect_pf("R8_evicted", 0, 0, 1);

        // R9: trigger while busy is dropped, table still advances
        acc(pb(60), 2'd0); acc(pb(60) + 1, 2'd0); acc(pb(60) + 2, 2'd0);
        acc(pb(62), 2'd0); acc(pb(62) + 1, 2'd0); acc(pb(62) + 2, 2'd0);
        drain();
        clear();
        acc(pb(60) + 3, 2'd0); acc(pb(62) + 3, 2'd0);
        drain();
        expect_pf("R9_dropped", 2, pb(60) + 4, 1);
        acc(pb(62) + 4, 2'd0);
        drain();
        expect_pf("R9_retrigger", 2, pb(62) + 5, 1);

        // R7, R3, R4, R6: sweep the trigger line over every page offset, both directions
        for (int d = 0; d < 2; d++) begin
            for (int e = 0; e < 128; e++) begin
                int p, line, n;
                p    = 100 + 2 * (d * 128 + e);
                line = pb(p) + e;
                for (int k = 3; k >= 0; k--) acc((d == 0) ? line - k : line + k, 2'(k % 3), e % 32);
                drain();
                if (d == 0) begin
                    n = (127 - e < 2) ? 127 - e : 2;
                    expect_pf("R3_R7_up", n, line + 1, 1);
                end else begin
                    n = (e < 2) ? e : 2;
                    expect_pf("R4_R7_down", n, line - 1, -1);
                end
            end
        end

        finish_run();
    end

endmodule